// File: doc/BRIEF.md
# Two-Level ALU Operation Decoder and Integer ALU

This block is the execute-stage arithmetic unit of a simple integer datapath, together with its local operation decoder. The main instruction decoder does not choose an ALU operation itself. It passes a 2-bit operation class. For register-to-register instructions it also passes the 6-bit function field of the instruction word. The local decoder turns these into a 4-bit operation code. The ALU then applies that operation to two 32-bit operands.

The ALU produces a data result, a flag that is high when that result is all zeros, and a signed overflow flag. Branch-on-equal uses the zero flag after a forced subtraction. Loads and stores use a forced addition to form an address. Immediate OR is served by the OR operation on an operand that is zero-extended outside this block. The block is purely combinational: every output follows its inputs within the same cycle, and it holds no state.

Top module: `alu_two_level`

## Requirements
- R1: When `alu_mode` is 2'b00, `op_code` is 4'b0010 (add), whatever the value of `fn_code`.
- R2: When `alu_mode` is 2'b01, `op_code` is 4'b0110 (subtract), whatever the value of `fn_code`.
- R3: When `alu_mode` is 2'b11, `op_code` is 4'b0001 (OR), whatever the value of `fn_code`.
- R4: When `alu_mode` is 2'b10, `fn_code` is decoded as follows: 6'h20 gives add 4'b0010, 6'h22 gives subtract 4'b0110, 6'h24 gives AND 4'b0000, 6'h25 gives OR 4'b0001, 6'h27 gives NOR 4'b1100, and 6'h2A gives set-less-than 4'b0111.
- R5: When `alu_mode` is 2'b10 and `fn_code` is any value not listed in R4, `op_code` is 4'b0010 (add).
- R6: `result` is the bitwise AND, OR or NOR of the operands for those codes. It is the sum modulo 2^32 for add, and the difference A minus B modulo 2^32 for subtract.
- R7: For set-less-than, `result` bit 0 is 1 exactly when A is less than B as signed two's-complement numbers, and every other result bit is 0. This holds even when the internal subtraction overflows.
- R8: `zero_flag` is 1 exactly when all bits of `result` are 0, for every operation.
- R9: For add and subtract, `ovf_flag` is 1 exactly when the true signed result does not fit in 32 bits.
- R10: For AND, OR, NOR and set-less-than, `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_mode | input | 2 | Operation class from the main decoder |
| fn_code | input | 6 | Function field of the instruction word |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register or extended immediate) |
| op_code | output | 4 | Decoded 4-bit ALU operation |
| result | output | 32 | ALU result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow for add and subtract |

## Verification
The hardest case to reach is set-less-than with operands whose difference overflows. In that case the sign bit of the raw difference gives the wrong answer, and only the overflow correction yields the right one. Uniform random operands reach it only now and then. The stimulus therefore mixes random vectors with operands drawn from the extreme values (the most negative and most positive numbers, -1, 0 and 1). Directed pairs such as the most negative number against 1 are added on top. Exact zero results from add and subtract are also rare at random, so operands are sometimes made equal or negated on purpose.

// File: rtl/alu_two_level_pkg.sv
package alu_two_level_pkg;

    localparam int unsigned MODE_W = 2;
    localparam int unsigned FN_W   = 6;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_FORCE_ADD = 2'b00,
        MODE_FORCE_SUB = 2'b01,
        MODE_BY_FIELD  = 2'b10,
        MODE_FORCE_OR  = 2'b11
    } alu_mode_e;

    typedef enum logic [CODE_W-1:0] {
        OPC_AND = 4'b0000,
        OPC_OR  = 4'b0001,
        OPC_ADD = 4'b0010,
        OPC_SUB = 4'b0110,
        OPC_SLT = 4'b0111,
        OPC_NOR = 4'b1100
    } alu_opc_e;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_two_level_pkg::*;
(
    input  logic [MODE_W-1:0] mode_in,
    input  logic [FN_W-1:0]   fn_in,
    output alu_opc_e          opc_out
);

    alu_opc_e field_opc;

    // second level: function field, only consulted for register class
    always_comb begin
        unique case (fn_in)
            FN_ADD:  field_opc = OPC_ADD;
            FN_SUB:  field_opc = OPC_SUB;
            FN_AND:  field_opc = OPC_AND;
            FN_OR:   field_opc = OPC_OR;
            FN_NOR:  field_opc = OPC_NOR;
            FN_SLT:  field_opc = OPC_SLT;
            default: field_opc = OPC_ADD;
        endcase
    end

    // first level: operation class
    always_comb begin
        unique case (alu_mode_e'(mode_in))
            MODE_FORCE_ADD: opc_out = OPC_ADD;
            MODE_FORCE_SUB: opc_out = OPC_SUB;
            MODE_BY_FIELD:  opc_out = field_opc;
            MODE_FORCE_OR:  opc_out = OPC_OR;
            default:        opc_out = OPC_ADD;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             ovf_out,
    output logic             less_out
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff    = sub_in ? ~b_in : b_in;
        sum_out  = a_in + b_eff + {{(WIDTH-1){1'b0}}, sub_in};
        // operands of equal sign giving a result of the other sign
        ovf_out  = (a_in[MSB] == b_eff[MSB]) && (sum_out[MSB] != a_in[MSB]);
        // sign of difference, corrected when the difference overflowed
        less_out = sum_out[MSB] ^ ovf_out;
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_two_level_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  alu_opc_e         opc_in,
    output logic [WIDTH-1:0] logic_out
);

    always_comb begin
        unique case (opc_in)
            OPC_AND: logic_out = a_in & b_in;
            OPC_OR:  logic_out = a_in | b_in;
            OPC_NOR: logic_out = ~(a_in | b_in);
            default: logic_out = '0;
        endcase
    end

endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
    import alu_two_level_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       alu_mode,
    input  logic [5:0]       fn_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [3:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);

    alu_opc_e         opc;
    logic             arith_sub;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_ovf;
    logic             arith_less;
    logic [WIDTH-1:0] bit_res;

    alu_op_decode u_decode (
        .mode_in (alu_mode),
        .fn_in   (fn_code),
        .opc_out (opc)
    );

    assign arith_sub = (opc == OPC_SUB) || (opc == OPC_SLT);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .sub_in   (arith_sub),
        .sum_out  (arith_sum),
        .ovf_out  (arith_ovf),
        .less_out (arith_less)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .opc_in    (opc),
        .logic_out (bit_res)
    );

    always_comb begin
        unique case (opc)
            OPC_ADD, OPC_SUB: begin
                result   = arith_sum;
                ovf_flag = arith_ovf;
            end
            OPC_SLT: begin
                result   = {{(WIDTH-1){1'b0}}, arith_less};
                ovf_flag = 1'b0;
            end
            default: begin
                result   = bit_res;
                ovf_flag = 1'b0;
            end
        endcase
    end

    assign op_code   = opc;
    assign zero_flag = ~|result;

endmodule

// File: rtl/alu_two_level_chk.sv
module alu_two_level_chk
    import alu_two_level_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic [1:0]       alu_mode,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             ovf_flag
);

    localparam int unsigned MSB = WIDTH - 1;

    always_comb begin
        if (alu_mode == 2'b00)
            assert_force_add_R1: assert (op_code == 4'b0010);
        if (alu_mode == 2'b01)
            assert_force_sub_R2: assert (op_code == 4'b0110);
        if (alu_mode == 2'b11)
            assert_force_or_R3: assert (op_code == 4'b0001);
        // R4, R5: only the six legal codes ever appear
        assert_legal_code_R4: assert (op_code == 4'b0000 || op_code == 4'b0001 ||
                                      op_code == 4'b0010 || op_code == 4'b0110 ||
                                      op_code == 4'b0111 || op_code == 4'b1100);
        if (op_code == 4'b0111)
            assert_slt_upper_R7: assert (result[MSB:1] == '0);
        if (op_code == 4'b0110)
            assert_sub_zero_R8: assert (zero_flag == (opnd_a == opnd_b));
        if (op_code == 4'b0010)
            assert_add_ovf_R9: assert (ovf_flag == ((opnd_a[MSB] == opnd_b[MSB]) &&
                                                    (result[MSB] != opnd_a[MSB])));
        if (op_code == 4'b0000 || op_code == 4'b0001 ||
            op_code == 4'b0111 || op_code == 4'b1100)
            assert_no_overflow_R10: assert (!ovf_flag);
    end

endmodule

bind alu_two_level alu_two_level_chk #(.WIDTH(WIDTH)) u_chk (
    .alu_mode  (alu_mode),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_alu_two_level.sv
module test_alu_two_level;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alu_mode = 2'b00;
    logic [5:0]  fn_code = 6'h00;
    logic [31:0] opnd_a = 32'h0;
    logic [31:0] opnd_b = 32'h0;
    logic [3:0]  op_code;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    alu_two_level i_alu_two_level (
        .alu_mode  (alu_mode),
        .fn_code   (fn_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_code   (op_code),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run did not end, actual=%0d expected<100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [3:0] exp_code(input logic [1:0] m, input logic [5:0] f);
        if (m == 2'b00) return 4'b0010;
        if (m == 2'b01) return 4'b0110;
        if (m == 2'b11) return 4'b0001;
        case (f)
            6'h20: return 4'b0010;
            6'h22: return 4'b0110;
            6'h24: return 4'b0000;
            6'h25: return 4'b0001;
            6'h27: return 4'b1100;
            6'h2A: return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    function automatic logic [31:0] exp_result(input logic [3:0] c, input logic [31:0] a,
                                               input logic [31:0] b);
        case (c)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b1100: return ~(a | b);
            4'b0110: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [3:0] c, input logic [31:0] a,
                                     input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        if (c == 4'b0010) t = sa + sb;
        else if (c == 4'b0110) t = sa - sb;
        else return 1'b0;
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: mode=%b fn=%h a=%h b=%h actual=%h expected=%h",
                     tag, alu_mode, fn_code, opnd_a, opnd_b, act, exp);
        end
    endtask

    // apply one vector and check every output against the bench model
    task automatic apply(input logic [1:0] m, input logic [5:0] f,
                         input logic [31:0] a, input logic [31:0] b);
        logic [3:0]  c;
        logic [31:0] r;
        string       rt;
        @(negedge clk);
        alu_mode = m;
        fn_code  = f;
        opnd_a   = a;
        opnd_b   = b;
        @(posedge clk);
        #2;
        c = exp_code(m, f);
        if (m == 2'b00)      chk("R1 code", {28'h0, op_code}, {28'h0, c});
        else if (m == 2'b01) chk("R2 code", {28'h0, op_code}, {28'h0, c});
        else if (m == 2'b11) chk("R3 code", {28'h0, op_code}, {28'h0, c});
        else if (c == 4'b0010 && f != 6'h20) chk("R5 code", {28'h0, op_code}, {28'h0, c});
        else chk("R4 code", {28'h0, op_code}, {28'h0, c});
        r  = exp_result(c, a, b);
        rt = (c == 4'b0111) ? "R7 result" : "R6 result";
        chk(rt, result, r);
        chk("R8 zero", {31'h0, zero_flag}, {31'h0, (r == 32'h0)});
        if (c == 4'b0010 || c == 4'b0110)
            chk("R9 ovf", {31'h0, ovf_flag}, {31'h0, exp_ovf(c, a, b)});
        else
            chk("R10 ovf", {31'h0, ovf_flag}, 32'h0);
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 7))
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0000;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [5:0] pick_fn();
        case ($urandom_range(0, 7))
            0: return 6'h20;
            1: return 6'h22;
            2: return 6'h24;
            3: return 6'h25;
            4: return 6'h27;
            5: return 6'h2A;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        // reset state: all inputs zero
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 reset code", {28'h0, op_code}, 32'h2);
        chk("R8 reset zero", {31'h0, zero_flag}, 32'h1);
        chk("R9 reset ovf", {31'h0, ovf_flag}, 32'h0);

        // forced classes ignore the field
        apply(2'b00, 6'h22, 32'd5, 32'd7);
        apply(2'b01, 6'h20, 32'd9, 32'd9);
        apply(2'b11, 6'h24, 32'hF0F0_0000, 32'h0000_1234);
        // each decoded function
        apply(2'b10, 6'h20, 32'd10, 32'd20);
        apply(2'b10, 6'h22, 32'd10, 32'd20);
        apply(2'b10, 6'h24, 32'hFF00_FF00, 32'h0FF0_0FF0);
        apply(2'b10, 6'h25, 32'hFF00_0000, 32'h0000_00FF);
        apply(2'b10, 6'h27, 32'h0000_0000, 32'h0000_0000);
        apply(2'b10, 6'h27, 32'hFFFF_0000, 32'h0000_FFFF);
        // unknown functions fall back to add
        apply(2'b10, 6'h00, 32'd3, 32'd4);
        apply(2'b10, 6'h3F, 32'hFFFF_FFFF, 32'd1);
        apply(2'b10, 6'h2B, 32'd1, 32'd2);
        // overflow boundaries
        apply(2'b00, 6'h00, 32'h7FFF_FFFF, 32'd1);
        apply(2'b00, 6'h00, 32'h8000_0000, 32'h8000_0000);
        apply(2'b01, 6'h00, 32'h8000_0000, 32'd1);
        apply(2'b01, 6'h00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(2'b00, 6'h00, 32'h7FFF_FFFE, 32'd1);
        // set-less-than where the difference overflows
        apply(2'b10, 6'h2A, 32'h8000_0000, 32'd1);
        apply(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd0);
        apply(2'b10, 6'h2A, 32'd5, 32'd5);
        // exact zero from add
        apply(2'b00, 6'h00, 32'h1234_5678, 32'hEDCB_A988);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = pick_operand();
            b = pick_operand();
            case ($urandom_range(0, 9))
                0: b = a;
                1: b = -a;
                default: ;
            endcase
            apply(2'($urandom), pick_fn(), a, b);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule